// File: doc/BRIEF.md
# LCD Sync and Active-Window Timing Generator

This block produces the horizontal sync, vertical sync and pixel-data enable for a 320x240 TFT panel. The panel is fed over a parallel port that carries one pixel in one, two or three port clocks. All horizontal timing is counted in port clocks and scales with that clocks-per-pixel figure. The opening of the data window also carries a small per-mode correction, which covers the pipeline latency of an external bus-width adapter that sits between the port and the panel.

A two-bit mode input chooses the pixel format. The block samples it only at frame boundaries, so a change made mid-frame never tears a frame. The block exposes its column counter (in port clocks) and its line counter so that a downstream pixel fetcher can follow the raster. An unusable mode code parks the generator with both syncs high and raises an error flag.

Top module: `lcd_timing_gen`

## Requirements
- R1: Mode code 0 selects 1 port clock per pixel (16-bit RGB565), code 1 selects 2 (8-bit RGB565) and code 2 selects 3 (8-bit RGB888). A line lasts 336 x cpp port clocks. `h_count_o` runs from 0 to that value minus one and then returns to 0.
- R2: `hsync_n_o` is low for the first 2 x cpp port clocks of every line (columns 0 to 2*cpp-1) and high for the rest of the line.
- R3: `vsync_n_o` is low only on line 0, during columns 0 to 2*cpp-1, and high at every other time.
- R4: `de_o` is high from column 7*cpp+k through column 7*cpp+k+320*cpp-1. The correction k is 0, 3 and 5 for cpp 1, 2 and 3. Outside that range `de_o` is low.
- R5: `de_o` is asserted only on lines 2 to 241. Lines 0, 1, 242 and 243 are blanking lines and carry no data enable.
- R6: A frame has 244 lines. `v_line_o` advances by one when a line wraps. After line 243 it returns to 0.
- R7: Mode code 3 is invalid. One clock after it is sampled, `mode_err_o` is high, both syncs are high, `de_o` is low, and both counters are held at 0. A valid code that is sampled later clears the flag and starts a frame at column 0 of line 0.
- R8: The mode input is sampled on the first clock after reset, on every clock while the generator is parked, and on the last clock of line 243. At any other time a change on it has no effect until the next frame.
- R9: While reset is asserted, both syncs are high, `de_o` is low, both counters are 0 and `mode_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Pixel format code (0, 1, 2 valid; 3 invalid) |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Active pixel-data enable |
| h_count_o | output | 10 | Column position in port clocks |
| v_line_o | output | 8 | Line number within the frame, 0 to 243 |
| mode_err_o | output | 1 | Invalid mode sampled; generator parked |

## Verification
The assertions assume that `mode_i` is a settled two-bit value at each rising edge. They also assume that reset is released cleanly, so that the first sampled mode comes from a stable input. The stimulus changes `mode_i` only on falling clock edges, well away from the sampling edge. The bench also changes the mode deliberately in the middle of a frame, which shows that the counters and the stored mode stay consistent until the frame wraps. The range and wrap properties of the counters rest on the stored period, which only changes when the column counter is already at 0.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    // Panel geometry in pixel times and lines
    parameter int H_ACT     = 320;
    parameter int H_TOTAL   = 336;
    parameter int H_PULSE   = 2;
    parameter int H_LEAD    = 7;
    parameter int V_VIS     = 240;
    parameter int V_PRE     = 2;
    parameter int V_POST    = 2;
    parameter int V_PULSE   = 2;
    parameter int MAX_CPP   = 3;

    // Adapter pipeline correction in port clocks, per clocks-per-pixel
    parameter int CORR_CPP1 = 0;
    parameter int CORR_CPP2 = 3;
    parameter int CORR_CPP3 = 5;

    localparam int V_TOTAL  = V_PRE + V_VIS + V_POST;
    localparam int HCW      = $clog2(H_TOTAL * MAX_CPP);
    localparam int VCW      = $clog2(V_TOTAL);

    typedef enum logic [1:0] {
        FMT_W16_565 = 2'd0,
        FMT_W8_565  = 2'd1,
        FMT_W8_888  = 2'd2,
        FMT_BAD     = 2'd3
    } fmt_e;

    // Per-mode horizontal limits, all in port clocks; act_hi is exclusive
    typedef struct packed {
        logic           valid;
        logic [HCW-1:0] period;
        logic [HCW-1:0] hs_w;
        logic [HCW-1:0] vs_w;
        logic [HCW-1:0] act_lo;
        logic [HCW-1:0] act_hi;
    } hlim_t;

endpackage

// File: rtl/lcdt_timing_decode.sv
module lcdt_timing_decode
    import lcdt_pkg::*;
(
    input  fmt_e  fmt_i,
    output hlim_t lim_o
);

    int cpp;
    int corr;

    always_comb begin
        lim_o = '0;
        unique case (fmt_i)
            FMT_W16_565: begin cpp = 1; corr = CORR_CPP1; lim_o.valid = 1'b1; end
            FMT_W8_565:  begin cpp = 2; corr = CORR_CPP2; lim_o.valid = 1'b1; end
            FMT_W8_888:  begin cpp = 3; corr = CORR_CPP3; lim_o.valid = 1'b1; end
            default:     begin cpp = 1; corr = 0;         lim_o.valid = 1'b0; end
        endcase
        lim_o.period = HCW'(H_TOTAL * cpp);
        lim_o.hs_w   = HCW'(H_PULSE * cpp);
        lim_o.vs_w   = HCW'(V_PULSE * cpp);
        lim_o.act_lo = HCW'(H_LEAD * cpp + corr);
        lim_o.act_hi = HCW'(H_LEAD * cpp + corr + H_ACT * cpp);
    end

endmodule

// File: rtl/lcdt_hcount.sv
module lcdt_hcount
    import lcdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [HCW-1:0] period_i,
    output logic [HCW-1:0] hcnt_o,
    output logic           line_end_o
);

    typedef struct packed {
        logic [HCW-1:0] hcnt;
    } hst_t;

    hst_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        line_end_o = run_i && (st_q.hcnt == period_i - 1'b1);
        if (!run_i) begin
            st_d.hcnt = '0;
        end else if (line_end_o) begin
            st_d.hcnt = '0;
        end else begin
            st_d.hcnt = st_q.hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hcnt_o = st_q.hcnt;

    AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (st_q.hcnt < period_i)) else $error("column past period"); // R1
    AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_o |=> (st_q.hcnt == '0)) else $error("column did not wrap"); // R1

endmodule

// File: rtl/lcdt_vcount.sv
module lcdt_vcount
    import lcdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic           line_end_i,
    output logic [VCW-1:0] line_o,
    output logic           frame_end_o
);

    typedef struct packed {
        logic [VCW-1:0] line;
    } vst_t;

    vst_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        frame_end_o = line_end_i && (st_q.line == VCW'(V_TOTAL - 1));
        if (!run_i) begin
            st_d.line = '0;
        end else if (frame_end_o) begin
            st_d.line = '0;
        end else if (line_end_i) begin
            st_d.line = st_q.line + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.line < VCW'(V_TOTAL)) else $error("line past frame"); // R6
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && line_end_i && !frame_end_o) |=> (st_q.line == $past(st_q.line) + 1'b1))
        else $error("line did not advance"); // R6
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (st_q.line == '0)) else $error("frame did not wrap"); // R6

endmodule

// File: rtl/lcdt_sync_decode.sv
module lcdt_sync_decode
    import lcdt_pkg::*;
(
    input  hlim_t          lim_i,
    input  logic [HCW-1:0] hcnt_i,
    input  logic [VCW-1:0] line_i,
    output logic           hs_n_o,
    output logic           vs_n_o,
    output logic           de_o
);

    logic in_cols;
    logic in_rows;

    always_comb begin
        in_cols = (hcnt_i >= lim_i.act_lo) && (hcnt_i < lim_i.act_hi);
        in_rows = (line_i >= VCW'(V_PRE)) && (line_i < VCW'(V_PRE + V_VIS));
        hs_n_o  = !(lim_i.valid && (hcnt_i < lim_i.hs_w));
        vs_n_o  = !(lim_i.valid && (line_i == '0) && (hcnt_i < lim_i.vs_w));
        de_o    = lim_i.valid && in_cols && in_rows;
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode_i,
    output logic           hsync_n_o,
    output logic           vsync_n_o,
    output logic           de_o,
    output logic [HCW-1:0] h_count_o,
    output logic [VCW-1:0] v_line_o,
    output logic           mode_err_o
);

    typedef struct packed {
        fmt_e fmt;
        logic err;
    } top_t;

    top_t  st_d, st_q;
    hlim_t lim;
    logic  run;
    logic  line_end;
    logic  frame_end;
    logic  load;

    lcdt_timing_decode u_decode (
        .fmt_i (st_q.fmt),
        .lim_o (lim)
    );

    assign run = lim.valid;

    lcdt_hcount u_hcount (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .period_i   (lim.period),
        .hcnt_o     (h_count_o),
        .line_end_o (line_end)
    );

    lcdt_vcount u_vcount (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .line_end_i  (line_end),
        .line_o      (v_line_o),
        .frame_end_o (frame_end)
    );

    lcdt_sync_decode u_sync (
        .lim_i  (lim),
        .hcnt_i (h_count_o),
        .line_i (v_line_o),
        .hs_n_o (hsync_n_o),
        .vs_n_o (vsync_n_o),
        .de_o   (de_o)
    );

    // Mode is taken only while parked or on the last clock of a frame
    always_comb begin
        st_d = st_q;
        load = !run || frame_end;
        if (load) begin
            st_d.fmt = fmt_e'(mode_i);
            st_d.err = (fmt_e'(mode_i) == FMT_BAD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fmt <= FMT_BAD;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_err_o = st_q.err;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_end) |=> $stable(st_q.fmt)) else $error("mode changed mid-frame"); // R8
    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> (hsync_n_o && vsync_n_o && !de_o && h_count_o == '0 && v_line_o == '0))
        else $error("parked generator active"); // R7
    AST_VS_FIRST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n_o |-> (v_line_o == '0 && !hsync_n_o)) else $error("vsync off line 0"); // R3
    AST_DE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> hsync_n_o) else $error("data enable inside hsync"); // R2
    AST_DE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (v_line_o >= VCW'(V_PRE) && v_line_o < VCW'(V_PRE + V_VIS)))
        else $error("data enable on blanking line"); // R5

endmodule

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       hsync_n_o, vsync_n_o, de_o, mode_err_o;
    logic [9:0] h_count_o;
    logic [7:0] v_line_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cur    = 0;

    always #2 clk = ~clk;

    lcd_timing_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .hsync_n_o  (hsync_n_o),
        .vsync_n_o  (vsync_n_o),
        .de_o       (de_o),
        .h_count_o  (h_count_o),
        .v_line_o   (v_line_o),
        .mode_err_o (mode_err_o)
    );

    typedef struct packed {
        logic        start;
        logic [1:0]  mode;
        int unsigned line;
        int unsigned col;
        logic        hs;
        logic        vs;
        logic        de;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        // cpp 1: hsync 0..1, window 7..326
        '{1'b1, 2'd0,   0,   0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 2'd0,   0,   1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 2'd0,   0,   2, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0,   0, 335, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0,   1,   0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'd0,   1,   7, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0,   2,   6, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0,   2,   7, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd0,   2, 326, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd0,   2, 327, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0, 120, 100, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd0, 241,   7, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd0, 242,   7, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0, 243,   0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'd0, 243, 335, 1'b1, 1'b1, 1'b0},
        // cpp 2: hsync 0..3, window 17..656
        '{1'b1, 2'd1,   0,   3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 2'd1,   0,   4, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd1,   1,  17, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd1,   2,  16, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd1,   2,  17, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd1,   2, 656, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd1,   2, 657, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd1,   2, 671, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd1,   3,   0, 1'b0, 1'b1, 1'b0},
        // cpp 3: hsync 0..5, window 26..985
        '{1'b1, 2'd2,   0,   5, 1'b0, 1'b0, 1'b0},
        '{1'b0, 2'd2,   0,   6, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd2,   2,  25, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd2,   2,  26, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd2,   2, 985, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd2,   2, 986, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd2,   3,1007, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Apply reset with a mode; returns just after the edge that loads it (position 0)
    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n  = 1'b0;
        mode_i = m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        cur = 0;
    endtask

    task automatic advance_to(input int pos);
        repeat (pos - cur) @(posedge clk);
        cur = pos;
        @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: state while reset is held
        repeat (2) @(negedge clk);
        check("R9", "hsync_n", hsync_n_o, 1);
        check("R9", "vsync_n", vsync_n_o, 1);
        check("R9", "de", de_o, 0);
        check("R9", "h_count", h_count_o, 0);
        check("R9", "v_line", v_line_o, 0);
        check("R9", "mode_err", mode_err_o, 0);

        // Vector walk: R1 period/columns, R2 hsync, R3 vsync, R4 window, R5 rows, R6 lines
        for (int i = 0; i < NV; i++) begin
            int hper;
            hper = 336 * (int'(VEC[i].mode) + 1);
            if (VEC[i].start) do_reset(VEC[i].mode);
            advance_to(int'(VEC[i].line) * hper + int'(VEC[i].col));
            check("R2", $sformatf("hsync_n vec%0d", i), hsync_n_o, VEC[i].hs);
            check("R3", $sformatf("vsync_n vec%0d", i), vsync_n_o, VEC[i].vs);
            check(VEC[i].line inside {[2:241]} ? "R4" : "R5",
                  $sformatf("de vec%0d", i), de_o, VEC[i].de);
            check("R1", $sformatf("h_count vec%0d", i), h_count_o, VEC[i].col);
            check("R6", $sformatf("v_line vec%0d", i), v_line_o, VEC[i].line);
        end

        // R7: invalid mode parks the generator
        do_reset(2'd3);
        @(negedge clk);
        check("R7", "mode_err", mode_err_o, 1);
        check("R7", "hsync_n", hsync_n_o, 1);
        check("R7", "vsync_n", vsync_n_o, 1);
        check("R7", "de", de_o, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R7", "h_count held", h_count_o, 0);
        check("R7", "mode_err held", mode_err_o, 1);
        mode_i = 2'd0;
        @(posedge clk);
        @(negedge clk);
        check("R7", "mode_err cleared", mode_err_o, 0);
        check("R7", "restart hsync_n", hsync_n_o, 0);
        check("R7", "restart vsync_n", vsync_n_o, 0);
        check("R7", "restart h_count", h_count_o, 0);
        @(posedge clk);
        @(negedge clk);
        check("R7", "running h_count", h_count_o, 1);

        // R8: mid-frame mode change waits for the frame wrap; R6 wrap to line 0
        do_reset(2'd0);
        advance_to(3 * 336);
        mode_i = 2'd1;
        advance_to(3 * 336 + 2);
        check("R8", "old width hsync_n", hsync_n_o, 1);
        advance_to(244 * 336 - 1);
        check("R6", "last v_line", v_line_o, 243);
        check("R1", "last h_count", h_count_o, 335);
        advance_to(244 * 336);
        check("R6", "wrap v_line", v_line_o, 0);
        check("R6", "wrap h_count", h_count_o, 0);
        check("R3", "wrap vsync_n", vsync_n_o, 0);
        advance_to(244 * 336 + 3);
        check("R8", "new width hsync_n", hsync_n_o, 0);
        check("R8", "new width vsync_n", vsync_n_o, 0);
        advance_to(244 * 336 + 4);
        check("R8", "new width end hsync_n", hsync_n_o, 1);
        advance_to(244 * 336 + 2 * 672 + 17);
        check("R8", "new window de", de_o, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule